// File: doc/BRIEF.md
# Multi-Channel Fan PWM Generator

This block drives up to eight fan control lines with pulse-width modulated waveforms. Three shared timebases ("clock types" M, N and O) each scale the system clock down through a power-of-two stage followed by a linear stage. Each timebase then runs a period counter that wraps after a programmable count. Every output channel chooses one of these timebases. It compares the shared count against its own rise and fall points to form its waveform. Because several fans share one timebase, they switch in step with each other.

Software programs the block through a single-cycle register write port. One global word starts and stops all counting. One word per timebase holds its period and its divider exponents. One word per channel holds the rise point, the fall point, the timebase select and the enable. Rise and fall values written to a running, enabled channel are staged and only applied at the next wrap of the channel's timebase. This prevents runt pulses. While a channel is disabled, its staged values pass straight through.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset every output is low. The global run bit and all channel enables are clear.
- R2: A timebase word is written at address 1 + t (M = 1, N = 2, O = 3). Its fields are: period P in bits [7:0], linear divider L in bits [11:8], and exponent H in bits [15:12]. The counter advances once every D = 2^H × (L = 0 ? 1 : 2L) clocks. The output period is (P + 1) × D clocks.
- R3: A channel word is written at address 4 + n. Its fields are: rise R in bits [7:0], fall F in bits [15:8], select in bits [17:16], and enable in bit 18. For counter value c, the output is high when R ≤ c < F if R < F, and when c ≥ R or c < F if R > F. A point beyond P is never reached.
- R4: R = F = 0 gives 100 % duty. R = F ≠ 0 gives a constantly low output.
- R5: A channel with its enable clear drives low. Its timebase keeps counting, so re-enabling it resumes the same waveform.
- R6: Select code 0, 1 or 2 picks timebase M, N or O. The spare code 3 falls back to timebase M.
- R7: Bit 0 at address 0 is the global run bit. While it is clear, all dividers and counters freeze and every output holds its level.
- R8: Rise and fall values written to an enabled channel take effect only at the next wrap of its selected timebase. The output keeps the old waveform until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 19 | Register write data |
| pwm_out | output | 8 | Fan PWM outputs, one per channel |

## Verification
Several behaviours are checked by assertions on every cycle:
- a disabled channel is low one cycle later;
- a 0/0 compare pair gives a high output;
- staged compare values reach the active copy only on a timebase wrap;
- counters stay frozen while the run bit is clear;
- a wrap returns the count to zero.

Other behaviours depend on whole periods, so only the bench scenarios can show them. These are the actual duty and period produced by each divider setting and compare pair, the fallback of the spare select code, the held outputs while stopped, and the alignment of a mid-period update with the next period start. The bench measures these against a reference channel on the same timebase.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

   // Width of the per-channel timebase select field.
   localparam int SEL_W = 2;

   // Timebase used when a select code names no existing timebase.
   localparam logic [SEL_W-1:0] SRC_DEFAULT = '0;

   // Output level for counter value c with compare points rise/fall.
   function automatic logic level_at(input int unsigned c,
                                     input int unsigned rise,
                                     input int unsigned fall);
      if (rise == fall)     return (rise == 0);
      else if (rise < fall) return (c >= rise) && (c < fall);
      else                  return (c >= rise) || (c < fall);
   endfunction

endpackage

// File: rtl/fan_pwm_divider.sv
module fan_pwm_divider #(
   parameter int PER_W  = 8,
   parameter int HDIV_W = 4,
   parameter int LDIV_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HDIV_W-1:0] hdiv,
   input  logic [LDIV_W-1:0] ldiv,
   input  logic [PER_W-1:0]  period,
   output logic [PER_W-1:0]  cnt,
   output logic              wrap
);
   localparam int S1_W = (1 << HDIV_W) - 1;
   localparam int S2_W = LDIV_W + 1;

   logic [S1_W-1:0] c1;
   logic [S2_W-1:0] c2;
   logic [S1_W:0]   one_shift;
   logic [S1_W-1:0] s1_lim;
   logic [S2_W-1:0] s2_lim;
   logic            s1_done, s2_done, tick;

   always_comb begin
      one_shift = {{S1_W{1'b0}}, 1'b1} << hdiv;
      s1_lim    = S1_W'(one_shift - {{S1_W{1'b0}}, 1'b1});
      s2_lim    = (ldiv == '0) ? '0 : ({ldiv, 1'b0} - S2_W'(1));
      s1_done   = (c1 >= s1_lim);
      s2_done   = (c2 >= s2_lim);
      tick      = run & s1_done & s2_done;
      wrap      = tick & (cnt >= period);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c1  <= '0;
         c2  <= '0;
         cnt <= '0;
      end else if (run) begin
         if (s1_done) begin
            c1 <= '0;
            c2 <= s2_done ? '0 : c2 + S2_W'(1);
         end else begin
            c1 <= c1 + S1_W'(1);
         end
         if (tick) cnt <= wrap ? '0 : cnt + PER_W'(1);
      end
   end

endmodule

// File: rtl/fan_pwm_channel.sv
module fan_pwm_channel
   import fan_pwm_pkg::*;
#(
   parameter int PER_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [PER_W-1:0] cnt,
   input  logic [PER_W-1:0] stage_rise,
   input  logic [PER_W-1:0] stage_fall,
   output logic [PER_W-1:0] act_rise,
   output logic [PER_W-1:0] act_fall,
   output logic             pwm
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_rise <= '0;
         act_fall <= '0;
         pwm      <= 1'b0;
      end else begin
         if (load) begin
            act_rise <= stage_rise;
            act_fall <= stage_fall;
         end
         pwm <= en & level_at(32'(cnt), 32'(act_rise), 32'(act_fall));
      end
   end

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
   import fan_pwm_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   parameter int NUM_TYPES = 3,
   parameter int PER_W     = 8,
   parameter int HDIV_W    = 4,
   parameter int LDIV_W    = 4,
   localparam int CFG_W    = 2*PER_W + SEL_W + 1,
   localparam int ADDR_W   = $clog2(1 + NUM_TYPES + NUM_PORTS)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [NUM_PORTS-1:0] pwm_out
);
   localparam int TYPE_BASE = 1;
   localparam int PORT_BASE = 1 + NUM_TYPES;
   localparam int SEL_LSB   = 2*PER_W;
   localparam int EN_BIT    = 2*PER_W + SEL_W;

   if (NUM_TYPES < 1 || NUM_TYPES > (1 << SEL_W)) begin : g_bad_types
      $error("NUM_TYPES must be within 1 .. 2**SEL_W");
   end
   if (HDIV_W < 1 || HDIV_W > 5) begin : g_bad_hdiv
      $error("HDIV_W must be within 1 .. 5");
   end
   if (PER_W < 2 || LDIV_W < 1) begin : g_bad_width
      $error("PER_W must be at least 2 and LDIV_W at least 1");
   end
   if (PER_W + LDIV_W + HDIV_W > CFG_W) begin : g_bad_pack
      $error("timebase word does not fit the write data width");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end

   logic                                run_q;
   logic [NUM_TYPES-1:0][PER_W-1:0]     t_per;
   logic [NUM_TYPES-1:0][HDIV_W-1:0]    t_h;
   logic [NUM_TYPES-1:0][LDIV_W-1:0]    t_l;
   logic [NUM_TYPES-1:0][PER_W-1:0]     t_cnt;
   logic [NUM_TYPES-1:0]                t_wrap;
   logic [NUM_PORTS-1:0][PER_W-1:0]     p_rise, p_fall;
   logic [NUM_PORTS-1:0][SEL_W-1:0]     p_sel;
   logic [NUM_PORTS-1:0]                en_q;
   logic [NUM_PORTS-1:0]                port_load;
   logic [NUM_PORTS-1:0][PER_W-1:0]     act_rise, act_fall;

   // register write decode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         t_per  <= '0;
         t_h    <= '0;
         t_l    <= '0;
         p_rise <= '0;
         p_fall <= '0;
         p_sel  <= '0;
         en_q   <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == '0) run_q <= cfg_wdata[0];
         for (int t = 0; t < NUM_TYPES; t++) begin
            if (cfg_addr == ADDR_W'(TYPE_BASE + t)) begin
               t_per[t] <= cfg_wdata[PER_W-1:0];
               t_l[t]   <= cfg_wdata[PER_W +: LDIV_W];
               t_h[t]   <= cfg_wdata[PER_W+LDIV_W +: HDIV_W];
            end
         end
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (cfg_addr == ADDR_W'(PORT_BASE + p)) begin
               p_rise[p] <= cfg_wdata[PER_W-1:0];
               p_fall[p] <= cfg_wdata[PER_W +: PER_W];
               p_sel[p]  <= cfg_wdata[SEL_LSB +: SEL_W];
               en_q[p]   <= cfg_wdata[EN_BIT];
            end
         end
      end
   end

   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
      fan_pwm_divider #(
         .PER_W(PER_W), .HDIV_W(HDIV_W), .LDIV_W(LDIV_W)
      ) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run_q),
         .hdiv   (t_h[t]),
         .ldiv   (t_l[t]),
         .period (t_per[t]),
         .cnt    (t_cnt[t]),
         .wrap   (t_wrap[t])
      );
   end

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      logic [SEL_W-1:0] src;
      if (NUM_TYPES == (1 << SEL_W)) begin : g_full_map
         assign src = p_sel[i];
      end else begin : g_fallback
         assign src = (p_sel[i] < SEL_W'(NUM_TYPES)) ? p_sel[i] : SRC_DEFAULT;
      end

      // staged values apply at a wrap, or at once while disabled
      assign port_load[i] = t_wrap[src] | ~en_q[i];

      fan_pwm_channel #(.PER_W(PER_W)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (en_q[i]),
         .load       (port_load[i]),
         .cnt        (t_cnt[src]),
         .stage_rise (p_rise[i]),
         .stage_fall (p_fall[i]),
         .act_rise   (act_rise[i]),
         .act_fall   (act_fall[i]),
         .pwm        (pwm_out[i])
      );
   end

endmodule

// File: rtl/fan_pwm_gen_chk.sv
module fan_pwm_gen_chk #(
   parameter int NUM_PORTS = 8,
   parameter int NUM_TYPES = 3,
   parameter int PER_W     = 8
)(
   input logic                            clk,
   input logic                            rst_n,
   input logic                            run_q,
   input logic [NUM_TYPES-1:0][PER_W-1:0] t_cnt,
   input logic [NUM_TYPES-1:0]            t_wrap,
   input logic [NUM_PORTS-1:0]            en_q,
   input logic [NUM_PORTS-1:0]            port_load,
   input logic [NUM_PORTS-1:0][PER_W-1:0] act_rise,
   input logic [NUM_PORTS-1:0][PER_W-1:0] act_fall,
   input logic [NUM_PORTS-1:0]            pwm_out
);
   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_tchk
      p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !run_q |=> $stable(t_cnt[t]))
         else $error("counter moved while stopped");

      p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
         t_wrap[t] |=> (t_cnt[t] == '0))
         else $error("wrap did not return count to zero");
   end

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pchk
      p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[i] |=> !pwm_out[i])
         else $error("disabled channel drove high");

      p_full_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[i] && act_rise[i] == '0 && act_fall[i] == '0) |=> pwm_out[i])
         else $error("0/0 compare pair not high");

      p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[i] && !port_load[i]) |=> ($stable(act_rise[i]) && $stable(act_fall[i])))
         else $error("compare points changed outside a wrap");
   end

endmodule

bind fan_pwm_gen fan_pwm_gen_chk #(
   .NUM_PORTS(NUM_PORTS), .NUM_TYPES(NUM_TYPES), .PER_W(PER_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_q     (run_q),
   .t_cnt     (t_cnt),
   .t_wrap    (t_wrap),
   .en_q      (en_q),
   .port_load (port_load),
   .act_rise  (act_rise),
   .act_fall  (act_fall),
   .pwm_out   (pwm_out)
);

// File: tb/fan_pwm_gen_test.sv
module fan_pwm_gen_test;
   localparam int NP = 8;
   localparam int CW = 19;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [AW-1:0] cfg_addr;
   logic [CW-1:0] cfg_wdata;
   logic [NP-1:0] pwm;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   fan_pwm_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .pwm_out(pwm)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = AW'(addr);
      cfg_wdata = CW'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   function automatic int type_word(input int per, input int l, input int h);
      return per | (l << 8) | (h << 12);
   endfunction

   function automatic int port_word(input int r, input int f, input int sel, input int en);
      return r | (f << 8) | (sel << 16) | (en << 18);
   endfunction

   // number of counter values 0..per for which the line is high
   function automatic int exp_high(input int r, input int f, input int per);
      int n = 0;
      for (int c = 0; c <= per; c++) begin
         if (r == f)     n += (r == 0) ? 1 : 0;
         else if (r < f) n += (c >= r && c < f) ? 1 : 0;
         else            n += (c >= r || c < f) ? 1 : 0;
      end
      return n;
   endfunction

   task automatic high_count(input int p, input int n, output int h);
      h = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm[p]) h++;
      end
   endtask

   task automatic wait_rise(input int p);
      logic prev = pwm[p];
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (pwm[p] && !prev) break;
         prev = pwm[p];
      end
   endtask

   task automatic rise_gap(input int p, output int gap);
      logic prev;
      wait_rise(p);
      gap  = 0;
      prev = 1'b1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         gap++;
         if (pwm[p] && !prev) break;
         prev = pwm[p];
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int h, g, d, lows, changes;
      logic [NP-1:0] snap;
      logic prev4;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, all lines low, and still low once running with no channel enabled
      h = 0;
      repeat (20) begin @(negedge clk); if (pwm != '0) h++; end
      chk("R1 outputs low after reset", h, 0);
      wr(0, 1);
      h = 0;
      repeat (20) begin @(negedge clk); if (pwm != '0) h++; end
      chk("R1 channels disabled after reset", h, 0);

      // R3/R4: sweep compare pairs on timebase M, P=3, D=1
      wr(1, type_word(3, 0, 0));
      for (int r = 0; r <= 4; r++) begin
         for (int f = 0; f <= 4; f++) begin
            int p = (r * 5 + f) % NP;
            wr(4 + p, port_word(r, f, 0, 1));
            repeat (10) @(negedge clk);
            high_count(p, 8, h);
            chk((r == f) ? "R4 equal points" : "R3 compare window", h, 2 * exp_high(r, f, 3));
         end
      end
      for (int p = 0; p < NP; p++) wr(4 + p, 0);

      // R2: divider sweep on timebase N, P=1
      for (int hh = 0; hh <= 3; hh++) begin
         for (int ll = 0; ll <= 3; ll++) begin
            d = (1 << hh) * ((ll == 0) ? 1 : 2 * ll);
            wr(2, type_word(1, ll, hh));
            wr(5, port_word(0, 1, 1, 1));
            repeat (4 * d + 4) @(negedge clk);
            rise_gap(1, g);
            chk("R2 period clocks", g, 2 * d);
            high_count(1, 2 * d, h);
            chk("R2 high clocks", h, d);
         end
      end

      // R6: timebase O, P=9, H=1, L=3 -> D=12, period 120
      wr(3, type_word(9, 3, 1));
      wr(6, port_word(2, 7, 2, 1));
      repeat (260) @(negedge clk);
      rise_gap(2, g);
      chk("R6 select O period", g, 120);
      high_count(2, 120, h);
      chk("R6 select O duty", h, 60);

      // R6: spare code 3 falls back to timebase M (now P=5, D=1)
      wr(1, type_word(5, 0, 0));
      wr(7, port_word(0, 1, 3, 1));
      repeat (20) @(negedge clk);
      rise_gap(3, g);
      chk("R6 spare code period", g, 6);
      high_count(3, 6, h);
      chk("R6 spare code duty", h, 1);

      // R5: disable then re-enable channel 2
      wr(6, port_word(2, 7, 2, 0));
      repeat (3) @(negedge clk);
      high_count(2, 240, h);
      chk("R5 disabled low", h, 0);
      wr(6, port_word(2, 7, 2, 1));
      repeat (260) @(negedge clk);
      high_count(2, 120, h);
      chk("R5 re-enabled duty", h, 60);

      // R7: global stop holds all outputs
      wr(0, 0);
      repeat (2) @(negedge clk);
      snap = pwm;
      changes = 0;
      repeat (300) begin @(negedge clk); if (pwm != snap) changes++; end
      chk("R7 outputs held while stopped", changes, 0);
      wr(0, 1);
      rise_gap(2, g);
      chk("R7 resumes period", g, 120);

      // R8: mid-period update applies at the next wrap; channel 4 marks count 0
      wr(1, type_word(15, 0, 0));
      wr(8, port_word(0, 1, 0, 1));
      wr(9, port_word(0, 0, 0, 1));
      repeat (40) @(negedge clk);
      wait_rise(4);
      repeat (4) @(negedge clk);
      wr(9, port_word(5, 5, 0, 1));
      lows  = 0;
      prev4 = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (pwm[4] && !prev4) break;
         if (!pwm[5]) lows++;
         prev4 = pwm[4];
      end
      chk("R8 old waveform kept until wrap", lows, 0);
      chk("R8 new waveform from wrap", int'(pwm[5]), 0);
      high_count(5, 32, h);
      chk("R4 nonzero equal points low", h, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule